// File: doc/BRIEF.md
# ALU Status Flag Unit

This block derives and holds the four status bits of a small 8-bit ALU: carry, overflow, not-zero and negative. It does not compute operands or drive the bus. It watches the byte currently on the system bus and a few signals taken from the ALU datapath:

- bit 7 of the adder sum;
- bit 7 of the bitwise XOR of the two operands;
- the top and bottom bits of the first operand;
- the adder carry-out, already corrected for subtraction;
- an explicit carry value.

When the latch strobe is low at a rising clock edge, all four flags are captured together into one register.

The carry source is chosen directly from the active-low output enables that the control logic already drives to select which datapath unit writes to the bus. No encoded selector is used. Each source is forced high while its enable is inactive, and the gated sources are then ANDed together. Any of the three logic-operation enables selects the explicit carry value. This lets logic operations clear carry, and it also serves the set, clear and complement carry operations. A flag that the current operation does not produce is still written; its value then carries no meaning.

All pins are plain status or control levels sampled on the clock. There is no streaming interface and no back-pressure.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst_n` is low, `flags` is 4'b0000.
- R2: At a rising edge with `latch_n` low, all four flag bits are loaded together. With `latch_n` high, `flags` keeps its value.
- R3: The not-zero flag loads the OR of all bits of `bus_data`, so any nonzero bus byte loads 1.
- R4: The negative flag loads `sum_msb`.
- R5: The overflow flag loads `~xor_msb & (w_msb ^ sum_msb)`.
- R6: With `oe_add_n` low, the carry flag loads `add_cout`.
- R7: With `oe_shl_n` low, the carry flag loads `w_msb`.
- R8: With `oe_shr_n` low, the carry flag loads `w_lsb`.
- R9: With any one of `oe_and_n`, `oe_or_n` or `oe_xor_n` low, the carry flag loads `carry_force`.
- R10: With all six enables high, the carry flag loads 1.
- R11: `flags` is packed as bit 3 carry, bit 2 overflow, bit 1 not-zero, bit 0 negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 8 | Byte currently on the system bus |
| sum_msb | input | 1 | Adder result bit 7 |
| xor_msb | input | 1 | Bit 7 of operand XOR |
| w_msb | input | 1 | First operand bit 7 |
| w_lsb | input | 1 | First operand bit 0 |
| add_cout | input | 1 | Corrected adder carry-out |
| carry_force | input | 1 | Explicit carry value for logic and carry operations |
| oe_add_n | input | 1 | Adder bus enable, active low |
| oe_shl_n | input | 1 | Left shift bus enable, active low |
| oe_shr_n | input | 1 | Right shift bus enable, active low |
| oe_and_n | input | 1 | AND bus enable, active low |
| oe_or_n | input | 1 | OR bus enable, active low |
| oe_xor_n | input | 1 | XOR bus enable, active low |
| latch_n | input | 1 | Flag capture strobe, active low |
| flags | output | 4 | Stored flags {carry, overflow, not-zero, negative} |

## Verification
The carry checks assume that at most one of the six output enables is low in any cycle. The control logic never drives two units onto the bus at once, and the wired-AND selection only gives a meaningful carry under that condition. The checker asserts this as a property of the inputs. The bench changes enables only through a task that clears exactly one of them, or none. Inputs are driven on the falling edge, so the values sampled at each capture edge are settled.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int DATA_W      = 8;
  localparam int N_CARRY_SRC = 4;
  localparam int N_LOGIC_OE  = 3;

  typedef struct packed {
    logic carry;
    logic ovf;
    logic nz;
    logic neg;
  } flag_t;

  localparam int FLAG_W = $bits(flag_t);
endpackage

// File: rtl/flag_nz_detect.sv
module flag_nz_detect #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] value,
  output logic             nonzero
);
  always_comb nonzero = |value;
endmodule

// File: rtl/flag_carry_mux.sv
// Active-low wired-AND selector: a source passes while its enable is low,
// otherwise it is forced high; the gated sources are ANDed.
module flag_carry_mux #(
  parameter int N_SRC = 4
) (
  input  logic [N_SRC-1:0] src,
  input  logic [N_SRC-1:0] sel_n,
  output logic             carry
);
  logic [N_SRC-1:0] gated;

  for (genvar i = 0; i < N_SRC; i++) begin : g_gate
    assign gated[i] = src[i] | sel_n[i];
  end

  assign carry = &gated;
endmodule

// File: rtl/flag_store.sv
module flag_store #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (!load_n) q <= d;
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import flag_pkg::*;
#(
  parameter int BUS_W = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_data,
  input  logic             sum_msb,
  input  logic             xor_msb,
  input  logic             w_msb,
  input  logic             w_lsb,
  input  logic             add_cout,
  input  logic             carry_force,
  input  logic             oe_add_n,
  input  logic             oe_shl_n,
  input  logic             oe_shr_n,
  input  logic             oe_and_n,
  input  logic             oe_or_n,
  input  logic             oe_xor_n,
  input  logic             latch_n,
  output logic [FLAG_W-1:0] flags
);
  logic [N_LOGIC_OE-1:0]  logic_oe_n;
  logic                   logic_sel_n;
  logic [N_CARRY_SRC-1:0] c_src;
  logic [N_CARRY_SRC-1:0] c_sel_n;
  logic                   carry_next;
  logic                   nz_next;
  flag_t                  next_flags;
  logic [FLAG_W-1:0]      stored;

  // Any logic-op enable low selects the explicit carry value.
  assign logic_oe_n  = {oe_xor_n, oe_or_n, oe_and_n};
  assign logic_sel_n = &logic_oe_n;

  assign c_src   = {carry_force, w_lsb,    w_msb,    add_cout};
  assign c_sel_n = {logic_sel_n, oe_shr_n, oe_shl_n, oe_add_n};

  flag_carry_mux #(.N_SRC(N_CARRY_SRC)) u_cmux (
    .src   (c_src),
    .sel_n (c_sel_n),
    .carry (carry_next)
  );

  flag_nz_detect #(.WIDTH(BUS_W)) u_nz (
    .value   (bus_data),
    .nonzero (nz_next)
  );

  always_comb begin
    next_flags.carry = carry_next;
    next_flags.ovf   = ~xor_msb & (w_msb ^ sum_msb);
    next_flags.nz    = nz_next;
    next_flags.neg   = sum_msb;
  end

  flag_store #(.WIDTH(FLAG_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_n (latch_n),
    .d      (next_flags),
    .q      (stored)
  );

  assign flags = stored;
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_data,
  input logic       sum_msb,
  input logic       xor_msb,
  input logic       w_msb,
  input logic       w_lsb,
  input logic       add_cout,
  input logic       carry_force,
  input logic       oe_add_n,
  input logic       oe_shl_n,
  input logic       oe_shr_n,
  input logic       oe_and_n,
  input logic       oe_or_n,
  input logic       oe_xor_n,
  input logic       latch_n,
  input logic [3:0] flags
);
  logic [5:0] oe_act;
  assign oe_act = ~{oe_add_n, oe_shl_n, oe_shr_n, oe_and_n, oe_or_n, oe_xor_n};

  always @(posedge clk) begin
    if (!rst_n) p_reset_clear_r1: assert (flags == 4'b0000);
  end

  p_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oe_act) <= 1);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_n |=> $stable(flags));

  p_not_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_n |=> flags[1] == $past(|bus_data));

  p_negative_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_n |=> flags[0] == $past(sum_msb));

  p_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_n |=> flags[2] == $past(~xor_msb & (w_msb ^ sum_msb)));

  p_carry_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_n && !oe_add_n) |=> flags[3] == $past(add_cout));

  p_carry_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_n && !oe_shl_n) |=> flags[3] == $past(w_msb));

  p_carry_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_n && !oe_shr_n) |=> flags[3] == $past(w_lsb));

  p_carry_logic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_n && (!oe_and_n || !oe_or_n || !oe_xor_n)) |=> flags[3] == $past(carry_force));

  p_carry_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_n && oe_act == 6'b0) |=> flags[3]);
endmodule

bind alu_flag_unit alu_flag_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .sum_msb(sum_msb),
  .xor_msb(xor_msb), .w_msb(w_msb), .w_lsb(w_lsb), .add_cout(add_cout),
  .carry_force(carry_force), .oe_add_n(oe_add_n), .oe_shl_n(oe_shl_n),
  .oe_shr_n(oe_shr_n), .oe_and_n(oe_and_n), .oe_or_n(oe_or_n),
  .oe_xor_n(oe_xor_n), .latch_n(latch_n), .flags(flags)
);

// File: tb/sim_alu_flag_unit.sv
`timescale 1ns/1ps
module sim_alu_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_data = '0;
  logic       sum_msb = 0, xor_msb = 0, w_msb = 0, w_lsb = 0;
  logic       add_cout = 0, carry_force = 0;
  logic       oe_add_n = 1, oe_shl_n = 1, oe_shr_n = 1;
  logic       oe_and_n = 1, oe_or_n = 1, oe_xor_n = 1;
  logic       latch_n = 1;
  logic [3:0] flags;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  alu_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .sum_msb(sum_msb),
    .xor_msb(xor_msb), .w_msb(w_msb), .w_lsb(w_lsb), .add_cout(add_cout),
    .carry_force(carry_force), .oe_add_n(oe_add_n), .oe_shl_n(oe_shl_n),
    .oe_shr_n(oe_shr_n), .oe_and_n(oe_and_n), .oe_or_n(oe_or_n),
    .oe_xor_n(oe_xor_n), .latch_n(latch_n), .flags(flags)
  );

  // sel: 0 none, 1 add, 2 shl, 3 shr, 4 and, 5 or, 6 xor
  task automatic drive(input logic [7:0] b, input logic s7, input logic x7,
                       input logic w7, input logic w0, input logic co,
                       input logic cf, input int sel);
    @(negedge clk);
    bus_data = b; sum_msb = s7; xor_msb = x7; w_msb = w7; w_lsb = w0;
    add_cout = co; carry_force = cf;
    oe_add_n = (sel != 1); oe_shl_n = (sel != 2); oe_shr_n = (sel != 3);
    oe_and_n = (sel != 4); oe_or_n = (sel != 5); oe_xor_n = (sel != 6);
  endtask

  task automatic capture();
    latch_n = 1'b0;
    @(posedge clk); #1;
    latch_n = 1'b1;
  endtask

  task automatic check(input logic [3:0] exp, input string req);
    checks++;
    if (flags !== exp) begin
      failures++;
      $display("FAIL %s flags=%b expected=%b", req, flags, exp);
    end
  endtask

  task automatic t_reset();
    check(4'b0000, "R1");
  endtask

  task automatic t_not_zero();
    drive(8'h01, 0, 1, 0, 0, 0, 0, 4); capture(); check(4'b0010, "R3 bus=01");
    drive(8'h80, 0, 1, 0, 0, 0, 0, 5); capture(); check(4'b0010, "R3 bus=80");
    drive(8'h00, 0, 1, 0, 0, 0, 0, 6); capture(); check(4'b0000, "R3 bus=00");
  endtask

  task automatic t_negative();
    drive(8'h00, 1, 1, 1, 0, 0, 0, 1); capture(); check(4'b0001, "R4 sum7=1");
  endtask

  task automatic t_overflow();
    drive(8'h00, 1, 0, 0, 0, 0, 0, 1); capture(); check(4'b0101, "R5 pos+pos");
    drive(8'h00, 0, 0, 1, 0, 1, 0, 1); capture(); check(4'b1100, "R5 neg+neg");
    drive(8'h00, 1, 1, 0, 0, 0, 0, 1); capture(); check(4'b0001, "R5 mixed signs");
    drive(8'h00, 1, 0, 1, 0, 0, 0, 1); capture(); check(4'b0001, "R5 no sign change");
  endtask

  task automatic t_carry_add();
    drive(8'h00, 0, 1, 0, 1, 1, 0, 1); capture(); check(4'b1000, "R6 cout=1");
    drive(8'h00, 0, 1, 1, 1, 0, 1, 1); capture(); check(4'b0100 & 4'b0000, "R6 cout=0");
  endtask

  task automatic t_carry_shift();
    drive(8'h00, 1, 1, 1, 0, 0, 0, 2); capture(); check(4'b1001, "R7 w7=1");
    drive(8'h00, 0, 1, 0, 1, 1, 1, 2); capture(); check(4'b0000, "R7 w7=0");
    drive(8'h00, 0, 1, 0, 1, 0, 0, 3); capture(); check(4'b1000, "R8 w0=1");
    drive(8'h00, 1, 1, 1, 0, 1, 1, 3); capture(); check(4'b0001, "R8 w0=0");
  endtask

  task automatic t_carry_logic();
    drive(8'h00, 0, 1, 0, 0, 1, 1, 4); capture(); check(4'b1000, "R9 and force=1");
    drive(8'h00, 0, 1, 1, 1, 1, 0, 5); capture(); check(4'b0000, "R9 or force=0");
    drive(8'h00, 0, 1, 0, 0, 0, 1, 6); capture(); check(4'b1000, "R9 xor force=1");
    drive(8'h00, 0, 1, 1, 1, 1, 0, 6); capture(); check(4'b0000, "R9 xor force=0");
  endtask

  task automatic t_carry_idle();
    drive(8'h00, 0, 1, 0, 0, 0, 0, 0); capture(); check(4'b1000, "R10 no enable");
  endtask

  task automatic t_packing();
    drive(8'hFF, 1, 0, 0, 0, 1, 0, 1); capture(); check(4'b1111, "R11 all set");
    drive(8'h40, 0, 1, 0, 0, 0, 0, 4); capture(); check(4'b0010, "R11 nz only");
  endtask

  task automatic t_hold();
    drive(8'h00, 1, 0, 0, 0, 0, 0, 1); capture(); check(4'b0101, "R2 load");
    drive(8'hA5, 0, 1, 1, 1, 1, 1, 2);
    @(posedge clk); #1; check(4'b0101, "R2 hold 1");
    @(posedge clk); #1; check(4'b0101, "R2 hold 2");
    capture(); check(4'b1010, "R2 reload");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_not_zero();
    t_negative();
    t_overflow();
    t_carry_add();
    t_carry_shift();
    t_carry_logic();
    t_carry_idle();
    t_packing();
    t_hold();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule